// File: doc/BRIEF.md
# Receive Destination Address Filter

This block makes the accept-or-drop decision for each incoming Ethernet frame, based on the frame's 48-bit destination address and its length. The receive path presents the address, the frame length and the current filter mode bits, together with a one-cycle strobe. Exactly two cycles later, the block returns a one-cycle decision with a valid flag.

A frame is accepted if it passes any one of the following tests:
- unicast promiscuous mode is on;
- the frame is multicast and multicast promiscuous mode is on;
- the frame is broadcast and broadcast acceptance is on;
- the address matches one of sixteen valid exact-match entries;
- the frame's bit is set in a 4096-bit hash table.

A frame longer than the selected receive buffer is always dropped, whatever mode is active. Software loads the exact-match entries and the hash table through a single-word write port.

Top module: `rx_addr_filter`

## Requirements
- R1: Each strobe sampled on `frameValid` produces exactly one `decValid` pulse two rising edges later. Back-to-back strobes give back-to-back decisions. `decAccept` is low whenever `decValid` is low.
- R2: With `promiscUni` high, every frame that is not too long is accepted.
- R3: A frame is multicast when bit 0 of `dstAddr` is 1. Bits 7:0 of `dstAddr` hold destination byte 0, and byte k sits in bits 8k+7:8k. With `promiscMulti` high, multicast frames are accepted; a unicast frame gains nothing from this mode.
- R4: With `bcastAccept` high, a destination address of all ones is accepted.
- R5: Exact-match entry i uses register address 2i for its low word and 2i+1 for its high word.
  - The low word holds bytes 0 to 3, with byte 0 in bits 7:0.
  - The high word holds byte 4 in bits 7:0, byte 5 in bits 15:8, and the valid flag in bit 31.
  - A valid entry equal to the destination address accepts the frame.
- R6: An entry whose valid bit is 0 never causes acceptance, even when its address matches.
- R7: The hash value is ({byte5, byte4} >> s) & 0xFFF. The shift s is 4, 3, 2 or 0 for `hashSel` values 0, 1, 2 or 3.
- R8: Hash word w (0 to 127) is written at register address 128+w. Hash bits 11:5 select the word and bits 4:0 select the bit within it. A set bit accepts the frame.
- R9: A frame that passes no test is dropped.
- R10: A frame whose `frameLen` exceeds the buffer size is dropped, even in promiscuous mode. `bufSel` selects the size: 1, 2 and 3 give 1024, 512 and 256; 4, 5 and 6 give 16384, 8192 and 4096; 0 and 7 give 2048. A length equal to the size passes.
- R11: A register write sampled on one edge applies to any frame whose strobe is sampled on a later edge, including the very next one.
- R12: After reset, all entries are invalid, the hash table is clear and no decision is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle frame strobe |
| dstAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frameLen | input | 16 | Frame length in bytes |
| bufSel | input | 3 | Receive buffer size select |
| promiscUni | input | 1 | Accept every frame |
| promiscMulti | input | 1 | Accept every multicast frame |
| bcastAccept | input | 1 | Accept broadcast frames |
| hashSel | input | 2 | Hash window offset select |
| regWrEn | input | 1 | Table write strobe |
| regAddr | input | 8 | Table word address |
| regWrData | input | 32 | Table write data |
| decValid | output | 1 | Decision valid |
| decAccept | output | 1 | Frame accepted |

## Verification
Each kind of corrupted internal state shows up in the decision of the frame it touches, two cycles after that frame's strobe:
- An entry stored under the wrong index or byte order makes a matching address drop.
- A hash bit stored in the wrong word or bit position shows up under only one of the four window offsets.
- A stale captured mode bit makes the wrong frame of a back-to-back pair change its result.

A pipeline stage that drops or duplicates a valid flag shows at once as a missing or extra decision, or as a decision in the wrong cycle.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  typedef struct packed {
    logic capture;
    logic evalNow;
    logic tooLong;
    logic wrEntry;
    logic wrHash;
  } filtStrobes_t;
endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int LEN_W       = 16,
  parameter int NUM_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameValid,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [2:0]        bufSel,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output filtStrobes_t      strobes,
  output logic              decValid
);
  localparam int ENTRY_REGS = 2 * NUM_ENTRIES;

  logic        s1Valid;
  logic        s1TooLong;
  logic [31:0] bufLimit;

  always_comb begin
    case (bufSel)
      3'd1:    bufLimit = 32'd1024;
      3'd2:    bufLimit = 32'd512;
      3'd3:    bufLimit = 32'd256;
      3'd4:    bufLimit = 32'd16384;
      3'd5:    bufLimit = 32'd8192;
      3'd6:    bufLimit = 32'd4096;
      default: bufLimit = 32'd2048;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid   <= 1'b0;
      s1TooLong <= 1'b0;
      decValid  <= 1'b0;
    end else begin
      s1Valid   <= frameValid;
      s1TooLong <= frameValid && (32'(frameLen) > bufLimit);
      decValid  <= s1Valid;
    end
  end

  always_comb begin
    strobes.capture = frameValid;
    strobes.evalNow = s1Valid;
    strobes.tooLong = s1TooLong;
    strobes.wrEntry = regWrEn && !regAddr[REG_AW-1] && (32'(regAddr) < ENTRY_REGS);
    strobes.wrHash  = regWrEn && regAddr[REG_AW-1];
  end

  // Every strobe yields a decision two edges later, and no decision appears without one.
  assert_dec_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |=> ##1 decValid);
  assert_dec_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    decValid |-> $past(frameValid, 2));
endmodule

// File: rtl/rx_addr_filter_datapath.sv
module rx_addr_filter_datapath
  import rx_addr_filter_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int NUM_ENTRIES = 16,
  parameter int HASH_WORDS  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  filtStrobes_t      strobes,
  input  logic [47:0]       dstAddr,
  input  logic              promiscUni,
  input  logic              promiscMulti,
  input  logic              bcastAccept,
  input  logic [1:0]        hashSel,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic              decAccept
);
  localparam int ENT_IDX_W  = $clog2(NUM_ENTRIES);
  localparam int WORD_IDX_W = $clog2(HASH_WORDS);
  localparam int HASH_BITS  = WORD_IDX_W + 5;

  logic [31:0] entLo   [NUM_ENTRIES];
  logic [31:0] entHi   [NUM_ENTRIES];
  logic [31:0] hashTab [HASH_WORDS];

  logic [47:0] capAddr;
  logic        capUni, capMulti, capBcast;
  logic [1:0]  capSel;

  logic [NUM_ENTRIES-1:0] entryHit;
  logic [15:0]            hashKey, hashShifted;
  logic [HASH_BITS-1:0]   hashVal;
  logic                   hashHit, isMulti, isBcast, acceptNext;

  logic [ENT_IDX_W-1:0]  wrEntIdx;
  logic [WORD_IDX_W-1:0] wrWordIdx;
  assign wrEntIdx  = regAddr[ENT_IDX_W:1];
  assign wrWordIdx = regAddr[WORD_IDX_W-1:0];

  // Table storage: exact-match entries and the hash bit array
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entLo[i] <= '0;
        entHi[i] <= '0;
      end
      for (int w = 0; w < HASH_WORDS; w++) hashTab[w] <= '0;
    end else begin
      if (strobes.wrEntry) begin
        if (regAddr[0]) entHi[wrEntIdx] <= regWrData;
        else            entLo[wrEntIdx] <= regWrData;
      end
      if (strobes.wrHash) hashTab[wrWordIdx] <= regWrData;
    end
  end

  // Stage 1: capture the address and the mode bits that belong to this frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capAddr  <= '0;
      capUni   <= 1'b0;
      capMulti <= 1'b0;
      capBcast <= 1'b0;
      capSel   <= '0;
    end else if (strobes.capture) begin
      capAddr  <= dstAddr;
      capUni   <= promiscUni;
      capMulti <= promiscMulti;
      capBcast <= bcastAccept;
      capSel   <= hashSel;
    end
  end

  // All exact-match comparators evaluate in parallel
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gen_cmp
    assign entryHit[g] = entHi[g][31]
                      && (entHi[g][15:0] == capAddr[47:32])
                      && (entLo[g] == capAddr[31:0]);
  end

  assign hashKey = capAddr[47:32];

  always_comb begin
    case (capSel)
      2'd0:    hashShifted = hashKey >> 4;
      2'd1:    hashShifted = hashKey >> 3;
      2'd2:    hashShifted = hashKey >> 2;
      default: hashShifted = hashKey;
    endcase
    hashVal = hashShifted[HASH_BITS-1:0];
  end

  assign hashHit    = hashTab[hashVal[HASH_BITS-1:5]][hashVal[4:0]];
  assign isMulti    = capAddr[0];
  assign isBcast    = &capAddr;
  assign acceptNext = !strobes.tooLong
                   && (capUni || (isMulti && capMulti) || (isBcast && capBcast)
                       || (|entryHit) || hashHit);

  // Stage 2: registered decision
  always_ff @(posedge clk) begin
    if (!rst_n) decAccept <= 1'b0;
    else        decAccept <= strobes.evalNow && acceptNext;
  end

  assert_accept_only_when_eval_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobes.evalNow) |-> !decAccept);
  assert_oversize_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.evalNow && strobes.tooLong) |-> !decAccept);
  assert_promisc_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.evalNow && !strobes.tooLong && capUni) |-> decAccept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int LEN_W       = 16,
  parameter int NUM_ENTRIES = 16,
  parameter int HASH_WORDS  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameValid,
  input  logic [47:0]       dstAddr,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [2:0]        bufSel,
  input  logic              promiscUni,
  input  logic              promiscMulti,
  input  logic              bcastAccept,
  input  logic [1:0]        hashSel,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic              decValid,
  output logic              decAccept
);
  filtStrobes_t strobes;

  rx_addr_filter_ctrl #(
    .REG_AW(REG_AW), .LEN_W(LEN_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameLen(frameLen),
    .bufSel(bufSel), .regWrEn(regWrEn), .regAddr(regAddr),
    .strobes(strobes), .decValid(decValid)
  );

  rx_addr_filter_datapath #(
    .REG_AW(REG_AW), .NUM_ENTRIES(NUM_ENTRIES), .HASH_WORDS(HASH_WORDS)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .dstAddr(dstAddr),
    .promiscUni(promiscUni), .promiscMulti(promiscMulti), .bcastAccept(bcastAccept),
    .hashSel(hashSel), .regAddr(regAddr), .regWrData(regWrData),
    .decAccept(decAccept)
  );
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic [15:0] frameLen = '0;
  logic [2:0]  bufSel = '0;
  logic        promiscUni = 1'b0, promiscMulti = 1'b0, bcastAccept = 1'b0;
  logic [1:0]  hashSel = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        decValid, decAccept;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .dstAddr(dstAddr),
    .frameLen(frameLen), .bufSel(bufSel), .promiscUni(promiscUni),
    .promiscMulti(promiscMulti), .bcastAccept(bcastAccept), .hashSel(hashSel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .decValid(decValid), .decAccept(decAccept)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] mLo[16], mHi[16], mHash[128];
  bit    expQ[$];
  int    cycQ[$];
  string tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bufBytes(input logic [2:0] s);
    case (s)
      3'd1: return 1024; 3'd2: return 512; 3'd3: return 256;
      3'd4: return 16384; 3'd5: return 8192; 3'd6: return 4096;
      default: return 2048;
    endcase
  endfunction

  function automatic logic [11:0] hashOf(input logic [47:0] a, input logic [1:0] hs);
    logic [15:0] k;
    int sh;
    k = a[47:32];
    sh = (hs == 0) ? 4 : (hs == 1) ? 3 : (hs == 2) ? 2 : 0;
    return 12'((k >> sh) & 16'hFFF);
  endfunction

  function automatic bit model(input logic [47:0] a, input int len, input logic [2:0] bs,
                               input bit u, input bit m, input bit b, input logic [1:0] hs);
    logic [11:0] h;
    if (len > bufBytes(bs)) return 0;
    if (u) return 1;
    if (a[0] && m) return 1;
    if (&a && b) return 1;
    for (int i = 0; i < 16; i++)
      if (mHi[i][31] && mHi[i][15:0] == a[47:32] && mLo[i] == a[31:0]) return 1;
    h = hashOf(a, hs);
    return mHash[h[11:5]][h[4:0]];
  endfunction

  task automatic writeReg(input int adr, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = 8'(adr); regWrData = d;
    if (adr >= 128) mHash[adr-128] = d;
    else if (adr[0]) mHi[adr/2] = d;
    else mLo[adr/2] = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setEntry(input int idx, input logic [47:0] a, input bit v);
    writeReg(2*idx, a[31:0]);
    writeReg(2*idx+1, {v, 15'd0, a[47:32]});
  endtask

  task automatic setHashFor(input logic [47:0] a, input logic [1:0] hs);
    logic [11:0] h;
    h = hashOf(a, hs);
    writeReg(128 + int'(h[11:5]), mHash[h[11:5]] | (32'd1 << h[4:0]));
  endtask

  // Driver: presents one frame for one cycle and queues the expected decision
  task automatic sendFrame(input logic [47:0] a, input int len, input logic [2:0] bs,
                           input bit u, input bit m, input bit b, input logic [1:0] hs,
                           input string tag);
    dstAddr = a; frameLen = 16'(len); bufSel = bs;
    promiscUni = u; promiscMulti = m; bcastAccept = b; hashSel = hs;
    frameValid = 1'b1;
    expQ.push_back(model(a, len, bs, u, m, b, hs));
    cycQ.push_back(cyc + 2);
    tagQ.push_back(tag);
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  // Monitor: pops expected decisions as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!decValid) begin
        if (decAccept) check(0, "R1 accept without valid", 1, 0);
      end else if (expQ.size() == 0) begin
        check(0, "R1 unexpected decision", 1, 0);
      end else begin
        bit e; int c; string t;
        e = expQ.pop_front(); c = cycQ.pop_front(); t = tagQ.pop_front();
        check(decAccept == e, t, int'(decAccept), int'(e));
        check(cyc == c, {"R1 latency ", t}, cyc, c);
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    logic [47:0] uc, mc, ha;
    for (int i = 0; i < 16; i++) begin mLo[i] = '0; mHi[i] = '0; end
    for (int w = 0; w < 128; w++) mHash[w] = '0;
    uc = 48'h6655_4433_2210;
    mc = 48'h6655_4433_2211;
    ha = 48'hA53C_7788_9A10;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(decValid == 0, "R12 reset decValid", int'(decValid), 0);
    check(decAccept == 0, "R12 reset decAccept", int'(decAccept), 0);

    sendFrame(uc, 64, 0, 0, 0, 0, 0, "R12 R9 empty tables drop");
    sendFrame(uc, 64, 0, 1, 0, 0, 0, "R2 unicast promiscuous");
    sendFrame(mc, 64, 0, 0, 1, 0, 0, "R3 multicast promiscuous");
    sendFrame(uc, 64, 0, 0, 1, 0, 0, "R3 unicast under mcast promisc");
    sendFrame(48'hFFFF_FFFF_FFFF, 64, 0, 0, 0, 1, 0, "R4 broadcast accepted");
    sendFrame(48'hFFFF_FFFF_FFFF, 64, 0, 0, 0, 0, 0, "R4 broadcast disabled");
    repeat (3) @(negedge clk);

    setEntry(3, uc, 1);
    sendFrame(uc, 64, 0, 0, 0, 0, 0, "R5 exact match entry 3");
    sendFrame(uc ^ 48'h0100_0000_0000, 64, 0, 0, 0, 0, 0, "R5 byte5 mismatch");
    sendFrame(uc ^ 48'h0000_0000_0100, 64, 0, 0, 0, 0, 0, "R5 byte1 mismatch");
    setEntry(5, 48'h0102_0304_0506, 0);
    sendFrame(48'h0102_0304_0506, 64, 0, 0, 0, 0, 0, "R6 invalid entry ignored");
    setEntry(15, 48'h0A0B_0C0D_0E00, 1);
    sendFrame(48'h0A0B_0C0D_0E00, 64, 0, 0, 0, 0, 0, "R11 R5 entry 15 next cycle");
    repeat (3) @(negedge clk);

    for (int s = 0; s < 4; s++) begin
      logic [47:0] a;
      a = ha ^ (48'(s) << 40);
      setHashFor(a, 2'(s));
      for (int q = 0; q < 4; q++)
        sendFrame(a, 64, 0, 0, 0, 0, 2'(q), "R7 R8 hash window select");
    end
    sendFrame(48'h1357_2468_0002, 64, 0, 0, 0, 0, 3, "R9 no test passes");
    repeat (3) @(negedge clk);

    sendFrame(uc, 2049, 0, 1, 0, 0, 0, "R10 2049 over default drop");
    sendFrame(uc, 2048, 0, 1, 0, 0, 0, "R10 2048 at default accept");
    sendFrame(uc, 257, 3, 1, 0, 0, 0, "R10 257 over 256 drop");
    sendFrame(uc, 256, 3, 0, 0, 0, 0, "R10 256 exact match accept");
    sendFrame(uc, 16384, 4, 1, 0, 0, 0, "R10 16384 accept");
    sendFrame(uc, 4097, 6, 1, 0, 0, 0, "R10 4097 over 4096 drop");
    sendFrame(uc, 1025, 1, 1, 0, 0, 0, "R10 1025 over 1024 drop");
    sendFrame(uc, 600, 2, 1, 0, 0, 0, "R10 600 over 512 drop");
    sendFrame(uc, 8192, 5, 1, 0, 0, 0, "R10 8192 accept");
    sendFrame(uc, 2049, 7, 1, 0, 0, 0, "R10 code 7 is 2048");
    repeat (5) @(negedge clk);

    check(expQ.size() == 0, "R1 all decisions seen", expQ.size(), 0);
    finishRun();
  end
endmodule